// File: doc/BRIEF.md
# Set/Clear Paired Control Register Bank

This block is a 32-bit memory-mapped bank of control and status words. It sits behind a simple single-cycle register port with separate write and read strobes. Most words are plain storage. A few control words are reached through two addresses: writing ones to the lower address turns bits on, and writing ones to the address one word above turns them off. Software can therefore change single bits without a read-modify-write sequence. Two configuration (strap) words work the same way. Each also has a guard word two words above it. While the guard word is nonzero the guard blocks further setting, but clearing still works.

Three PLL extension words always show their lock flag (bit 31) as set when read, whatever was stored. Two revision words take their value from an input port at reset and ignore writes. A random-number word returns a fresh pseudo-random value on every read. A key word holds a one-bit unlocked flag. Writing the parameterised magic value sets the flag, and any other value clears it. Writes made while the flag is clear are reported on a one-cycle pulse but still take effect.

Top module: `scb_bank`

## Requirements
- R1: A write to 0x40, 0x50, 0x80 or 0x90 ORs the write data into that word. Bits already set stay set.
- R2: A write to 0x44, 0x54, 0x84 or 0x94 clears, in the word one address below, every bit that is 1 in the write data. The other bits keep their value.
- R3: A write to strap word 0x500 (or 0x510) ORs the data in only while its guard word 0x508 (or 0x518) reads zero. When the guard is nonzero the strap word keeps its value. Its clear alias 0x504 (or 0x514) clears bits whether or not the guard is set.
- R4: Reads of 0x204, 0x224 and 0x244 return the stored word with bit 31 forced to 1. Writes to these words store all 32 bits.
- R5: The revision words 0x04 and 0x14 both load the `rev_id` input during reset. They, and the random word 0x540, ignore every write.
- R6: A write to key word 0x00 stores 1 when the data equals 0xC0DE5AFE and 0 for any other value. The key word reads back as that single bit.
- R7: Every read of 0x540 returns a nonzero word that differs from the word returned by the previous read of 0x540.
- R8: `lock_viol` is high for exactly the cycle after an accepted write to any offset other than 0x00 made while the key word is 0. Such a write is still carried out. Writes to 0x00, and writes made while the key word is 1, produce no pulse.
- R9: After reset: 0x40 = 0xF7CFFFDC, 0x50 = 0xFFFFFFFC, 0x80 = 0xEFF43E8B, 0x90 = 0xFFF0FFF0, 0x100 = 0x00000040, 0x200 = 0x1000405F. The strap words hold `strap_a_init` and `strap_b_init`, and the key word holds `key_init`. Every other word is 0.
- R10: An access whose address is not a multiple of 4, or is at or above 0x1000, reads 0 and writes nothing. It also raises no `lock_viol` pulse.
- R11: Any other in-window word is plain read/write storage. The clear aliases (0x44, 0x54, 0x84, 0x94, 0x504, 0x514) always read 0.
- R12: `rdata` takes the addressed value at the clock edge where `rd_en` is high and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rev_id | input | 32 | Value loaded into both revision words at reset |
| strap_a_init | input | 32 | Reset value of strap word 0x500 |
| strap_b_init | input | 32 | Reset value of strap word 0x510 |
| key_init | input | 1 | Reset value of the key (unlocked) flag |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| addr | input | 16 | Byte address of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| lock_viol | output | 1 | One-cycle pulse for a write made while locked |

## Verification
The hardest case to reach is a guarded strap word. The guard word must first be made nonzero through an ordinary write. A set-write must then be shown to change nothing, while a clear-write in the same state must still remove bits. The bench reaches this state in order: an unguarded set, then a guard write, then a blocked set, then a clear that succeeds, with each step read back through the port. The lock pulse is the other hard case, because it exists only while the key is clear. It is therefore checked before the magic key is written, and checked again after.

// File: rtl/scb_pkg.sv
package scb_pkg;

   // word indices (byte offset / 4) of words with special behaviour
   localparam int unsigned W_KEY     = 'h000;
   localparam int unsigned W_REV_A   = 'h001;
   localparam int unsigned W_REV_B   = 'h005;
   localparam int unsigned W_RST0    = 'h010;
   localparam int unsigned W_RST1    = 'h014;
   localparam int unsigned W_GATE0   = 'h020;
   localparam int unsigned W_GATE1   = 'h024;
   localparam int unsigned W_HSHAKE  = 'h040;
   localparam int unsigned W_PLLP    = 'h080;
   localparam int unsigned W_PLLX0   = 'h081;
   localparam int unsigned W_PLLX1   = 'h089;
   localparam int unsigned W_PLLX2   = 'h091;
   localparam int unsigned W_STRAP_A = 'h140;
   localparam int unsigned W_STRAP_B = 'h144;
   localparam int unsigned W_RNG     = 'h150;
   localparam int unsigned N_PAIRS   = 4;
   localparam int unsigned N_STRAPS  = 2;
   localparam int unsigned HIGHEST_W = W_RNG;

   typedef enum logic [3:0] {
      K_NONE, K_KEY, K_RO, K_RNG, K_SET, K_CLR, K_SSET, K_SCLR, K_PLLX, K_PLAIN
   } scb_kind_e;

   function automatic int unsigned pair_base(int unsigned k);
      case (k)
         0: return W_RST0;
         1: return W_RST1;
         2: return W_GATE0;
         default: return W_GATE1;
      endcase
   endfunction

   function automatic int unsigned strap_base(int unsigned k);
      return (k == 0) ? W_STRAP_A : W_STRAP_B;
   endfunction

   // constant reset contents; port-loaded words are overlaid in the top
   function automatic logic [31:0] fixed_reset(int unsigned w);
      case (w)
         W_RST0:   return 32'hF7CF_FFDC;
         W_RST1:   return 32'hFFFF_FFFC;
         W_GATE0:  return 32'hEFF4_3E8B;
         W_GATE1:  return 32'hFFF0_FFF0;
         W_HSHAKE: return 32'h0000_0040;
         W_PLLP:   return 32'h1000_405F;
         default:  return 32'h0;
      endcase
   endfunction

endpackage

// File: rtl/scb_decode.sv
module scb_decode
   import scb_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned WIN_BYTES = 4096,
   localparam int unsigned IDX_W    = $clog2(WIN_BYTES / 4)
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic [IDX_W-1:0]  idx,
   output scb_kind_e         kind
);

   logic in_win;

   if (WIN_BYTES == (2 ** ADDR_W)) begin : g_full_win
      assign in_win = 1'b1;
   end else begin : g_part_win
      assign in_win = (addr < ADDR_W'(WIN_BYTES));
   end

   assign hit = in_win && (addr[1:0] == 2'b00);
   assign idx = addr[IDX_W+1:2];

   always_comb begin
      kind = K_PLAIN;
      case (32'(idx))
         W_KEY:                    kind = K_KEY;
         W_REV_A, W_REV_B:         kind = K_RO;
         W_RNG:                    kind = K_RNG;
         W_RST0, W_RST1,
         W_GATE0, W_GATE1:         kind = K_SET;
         W_RST0 + 1, W_RST1 + 1,
         W_GATE0 + 1, W_GATE1 + 1: kind = K_CLR;
         W_STRAP_A, W_STRAP_B:     kind = K_SSET;
         W_STRAP_A + 1,
         W_STRAP_B + 1:            kind = K_SCLR;
         W_PLLX0, W_PLLX1,
         W_PLLX2:                  kind = K_PLLX;
         default:                  kind = K_PLAIN;
      endcase
      if (!hit) kind = K_NONE;
   end

endmodule

// File: rtl/scb_lfsr.sv
module scb_lfsr #(
   parameter int unsigned W      = 32,
   parameter logic [W-1:0] SEED  = 32'h1D87_2B41,
   parameter logic [W-1:0] POLY  = 32'h8020_0003,
   parameter bit          GALOIS = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   output logic [W-1:0] state
);

   if (SEED == '0) begin : g_bad_seed
      $error("scb_lfsr: SEED must be nonzero");
   end
   if (!POLY[W-1]) begin : g_bad_poly
      $error("scb_lfsr: POLY must have its top bit set");
   end

   logic [W-1:0] nxt;

   if (GALOIS) begin : g_galois
      assign nxt = {1'b0, state[W-1:1]} ^ (state[0] ? POLY : '0);
   end else begin : g_fibo
      assign nxt = {state[W-2:0], ^(state & POLY)};
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    state <= SEED;
      else if (step) state <= nxt;
   end

   AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      state != '0); // R7

endmodule

// File: rtl/scb_bank.sv
module scb_bank
   import scb_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned WIN_BYTES = 4096,
   parameter logic [31:0] KEY_MAGIC = 32'hC0DE_5AFE,
   parameter int unsigned LOCK_BIT  = 31,
   parameter bit          RNG_GALOIS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] rev_id,
   input  logic [DATA_W-1:0] strap_a_init,
   input  logic [DATA_W-1:0] strap_b_init,
   input  logic              key_init,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              lock_viol
);

   localparam int unsigned WORDS = WIN_BYTES / 4;
   localparam int unsigned IDX_W = $clog2(WORDS);
   localparam logic [DATA_W-1:0] LOCK_MASK = DATA_W'(1) << LOCK_BIT;

   if (DATA_W != 32) begin : g_bad_width
      $error("scb_bank: DATA_W must be 32");
   end
   if (WORDS <= HIGHEST_W || (WIN_BYTES & (WIN_BYTES - 1)) != 0) begin : g_bad_win
      $error("scb_bank: WIN_BYTES must be a power of two above the highest special word");
   end
   if (ADDR_W < IDX_W + 2) begin : g_bad_addr
      $error("scb_bank: ADDR_W too narrow for the window");
   end
   if (LOCK_BIT >= DATA_W) begin : g_bad_lock
      $error("scb_bank: LOCK_BIT out of range");
   end

   logic [DATA_W-1:0] bank [WORDS];
   logic              hit;
   logic [IDX_W-1:0]  w_idx;
   scb_kind_e         kind;
   logic [DATA_W-1:0] rnd;
   logic [DATA_W-1:0] rd_val;
   logic              rng_step;
   logic              key_set;

   scb_decode #(.ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES)) u_dec (
      .addr (addr),
      .hit  (hit),
      .idx  (w_idx),
      .kind (kind)
   );

   assign rng_step = rd_en && (kind == K_RNG);

   scb_lfsr #(.W(DATA_W), .GALOIS(RNG_GALOIS)) u_rng (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (rng_step),
      .state (rnd)
   );

   assign key_set = bank[W_KEY][0];

   // ---------------- write side ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < WORDS; i++) bank[i] <= fixed_reset(i);
         bank[W_REV_A]   <= rev_id;
         bank[W_REV_B]   <= rev_id;
         bank[W_STRAP_A] <= strap_a_init;
         bank[W_STRAP_B] <= strap_b_init;
         bank[W_KEY]     <= {{(DATA_W-1){1'b0}}, key_init};
      end else if (wr_en) begin
         case (kind)
            K_KEY:   bank[w_idx] <= {{(DATA_W-1){1'b0}}, (wdata == KEY_MAGIC)};
            K_SET:   bank[w_idx] <= bank[w_idx] | wdata;
            K_SSET:  if (bank[w_idx + IDX_W'(2)] == '0)
                        bank[w_idx] <= bank[w_idx] | wdata;
            K_CLR,
            K_SCLR:  bank[w_idx - IDX_W'(1)] <= bank[w_idx - IDX_W'(1)] & ~wdata;
            K_PLLX,
            K_PLAIN: bank[w_idx] <= wdata;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) lock_viol <= 1'b0;
      else        lock_viol <= wr_en && hit && (kind != K_KEY) && !key_set;
   end

   // ---------------- read side ----------------
   always_comb begin
      case (kind)
         K_NONE, K_CLR, K_SCLR: rd_val = '0;
         K_RNG:                 rd_val = rnd;
         K_PLLX:                rd_val = bank[w_idx] | LOCK_MASK;
         default:               rd_val = bank[w_idx];
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= rd_val;
   end

   // ---------------- assertions ----------------
   for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair_chk
      localparam int unsigned B = pair_base(p);
      AST_SET_ORS_IN: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && hit && 32'(w_idx) == B) |=>
            ((bank[B] & $past(wdata)) == $past(wdata))); // R1
      AST_CLR_REMOVES: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && hit && 32'(w_idx) == B + 1) |=>
            ((bank[B] & $past(wdata)) == '0)); // R2
   end

   for (genvar s = 0; s < N_STRAPS; s++) begin : g_strap_chk
      localparam int unsigned S = strap_base(s);
      AST_STRAP_GUARDED: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && hit && 32'(w_idx) == S && bank[S+2] != '0) |=>
            ((bank[S] & ~$past(bank[S])) == '0)); // R3
   end

   AST_PLL_LOCK_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && kind == K_PLLX) |=> rdata[LOCK_BIT]); // R4

   AST_REV_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ($stable(bank[W_REV_A]) && $stable(bank[W_REV_B]))); // R5

   AST_VIOL_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      lock_viol |-> $past(wr_en)); // R8

   AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !hit) |=> (rdata == '0)); // R10

   AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_en && $past(rst_n)) |=> $stable(rdata)); // R12

endmodule

// File: tb/tb_scb_bank.sv
module tb_scb_bank;

   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] REV   = 32'h0503_0303;
   localparam logic [31:0] SA    = 32'h0000_1000;
   localparam logic [31:0] SB    = 32'h0000_0041;
   localparam logic [31:0] MAGIC = 32'hC0DE_5AFE;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [15:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        lock_viol;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   scb_bank dut (
      .clk (clk), .rst_n (rst_n), .rev_id (REV),
      .strap_a_init (SA), .strap_b_init (SB), .key_init (1'b0),
      .wr_en (wr_en), .rd_en (rd_en), .addr (addr), .wdata (wdata),
      .rdata (rdata), .lock_viol (lock_viol)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   // write; returns the lock_viol level seen the cycle after the write
   task automatic wr(input logic [15:0] a, input logic [31:0] d, output logic lv);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
      lv = lock_viol;
   endtask

   task automatic rd(input logic [15:0] a, output logic [31:0] v);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      @(posedge clk);
      @(negedge clk);
      rd_en = 1'b0;
      v = rdata;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(16'h0040, v); check("R9 0x40", v, 32'hF7CF_FFDC);
      rd(16'h0050, v); check("R9 0x50", v, 32'hFFFF_FFFC);
      rd(16'h0080, v); check("R9 0x80", v, 32'hEFF4_3E8B);
      rd(16'h0090, v); check("R9 0x90", v, 32'hFFF0_FFF0);
      rd(16'h0100, v); check("R9 0x100", v, 32'h0000_0040);
      rd(16'h0200, v); check("R9 0x200", v, 32'h1000_405F);
      rd(16'h0500, v); check("R9 strap a", v, SA);
      rd(16'h0510, v); check("R9 strap b", v, SB);
      rd(16'h0000, v); check("R9 key", v, 32'h0);
      rd(16'h0300, v); check("R9 plain zero", v, 32'h0);
      rd(16'h0004, v); check("R5 rev a", v, REV);
      rd(16'h0014, v); check("R5 rev b", v, REV);
   endtask

   task automatic t_lock();
      logic [31:0] v;
      logic lv;
      wr(16'h0300, 32'h1234_5678, lv); check("R8 pulse while locked", 32'(lv), 32'h1);
      @(negedge clk);                  check("R8 pulse one cycle", 32'(lock_viol), 32'h0);
      rd(16'h0300, v);                 check("R8 locked write applied", v, 32'h1234_5678);
      wr(16'h0000, 32'h0000_0001, lv); check("R8 key write no pulse", 32'(lv), 32'h0);
      rd(16'h0000, v);                 check("R6 wrong key stores 0", v, 32'h0);
      wr(16'h0000, MAGIC, lv);
      rd(16'h0000, v);                 check("R6 magic stores 1", v, 32'h1);
      wr(16'h0304, 32'hA5A5_0000, lv); check("R8 no pulse unlocked", 32'(lv), 32'h0);
      rd(16'h0304, v);                 check("R11 plain rw", v, 32'hA5A5_0000);
   endtask

   task automatic t_setclr();
      logic [31:0] v;
      logic [31:0] dflt [4] = '{32'hF7CF_FFDC, 32'hFFFF_FFFC, 32'hEFF4_3E8B, 32'hFFF0_FFF0};
      logic [15:0] base [4] = '{16'h0040, 16'h0050, 16'h0080, 16'h0090};
      logic lv;
      for (int k = 0; k < 4; k++) begin
         wr(base[k], 32'h0000_0003, lv);
         rd(base[k], v);            check("R1 set ors", v, dflt[k] | 32'h3);
         wr(base[k] + 16'h4, 32'hF000_0001, lv);
         rd(base[k], v);            check("R2 clear bits", v, (dflt[k] | 32'h3) & ~32'hF000_0001);
         rd(base[k] + 16'h4, v);    check("R11 clear alias reads 0", v, 32'h0);
      end
   endtask

   task automatic t_strap();
      logic [31:0] v;
      logic lv;
      wr(16'h0500, 32'h0000_0022, lv);
      rd(16'h0500, v); check("R3 unguarded set", v, 32'h0000_1022);
      wr(16'h0508, 32'h0000_0001, lv);
      wr(16'h0500, 32'h0000_0400, lv);
      rd(16'h0500, v); check("R3 guarded set blocked", v, 32'h0000_1022);
      wr(16'h0504, 32'h0000_1000, lv);
      rd(16'h0500, v); check("R3 clear while guarded", v, 32'h0000_0022);
      wr(16'h0518, 32'h0000_0005, lv);
      rd(16'h0518, v); check("R11 guard readback", v, 32'h0000_0005);
      wr(16'h0510, 32'h0000_0100, lv);
      rd(16'h0510, v); check("R3 strap b blocked", v, SB);
      wr(16'h0514, 32'h0000_0001, lv);
      rd(16'h0510, v); check("R3 strap b clear", v, 32'h0000_0040);
      rd(16'h0514, v); check("R11 strap clear alias reads 0", v, 32'h0);
   endtask

   task automatic t_pll();
      logic [31:0] v;
      logic lv;
      rd(16'h0244, v); check("R4 reset pll ext", v, 32'h8000_0000);
      wr(16'h0204, 32'h0000_1234, lv);
      rd(16'h0204, v); check("R4 lock forced", v, 32'h8000_1234);
      wr(16'h0224, 32'h8000_0005, lv);
      rd(16'h0224, v); check("R4 lock already set", v, 32'h8000_0005);
   endtask

   task automatic t_ro_rng();
      logic [31:0] v, prev;
      logic lv;
      wr(16'h0004, 32'hDEAD_BEEF, lv);
      wr(16'h0014, 32'h0000_0000, lv);
      rd(16'h0004, v); check("R5 rev a ignores write", v, REV);
      rd(16'h0014, v); check("R5 rev b ignores write", v, REV);
      wr(16'h0540, 32'h0000_0000, lv);
      rd(16'h0540, prev); check("R7 rng nonzero", 32'(prev != 0), 32'h1);
      for (int k = 0; k < 4; k++) begin
         rd(16'h0540, v);
         check("R7 rng nonzero", 32'(v != 0), 32'h1);
         check("R7 rng differs", 32'(v != prev), 32'h1);
         prev = v;
      end
   endtask

   task automatic t_miss();
      logic [31:0] v;
      logic lv;
      wr(16'h0000, 32'h0, lv);   // relock so a bad write would show a pulse
      wr(16'h030A, 32'hAAAA_AAAA, lv); check("R10 misaligned no pulse", 32'(lv), 32'h0);
      wr(16'h1308, 32'h5555_5555, lv); check("R10 outside no pulse", 32'(lv), 32'h0);
      rd(16'h0308, v); check("R10 stray writes dropped", v, 32'h0);
      rd(16'h030A, v); check("R10 misaligned reads 0", v, 32'h0);
      rd(16'h1040, v); check("R10 outside reads 0", v, 32'h0);
   endtask

   task automatic t_hold();
      logic [31:0] v;
      rd(16'h0050, v);
      repeat (3) @(negedge clk);
      check("R12 rdata held", rdata, v);
      check("R12 value read", v, (32'hFFFF_FFFC | 32'h3) & ~32'hF000_0001);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R9 rdata in reset", rdata, 32'h0);
      rst_n = 1'b1;
      t_reset();
      t_lock();
      t_setclr();
      t_strap();
      t_pll();
      t_ro_rng();
      t_miss();
      t_hold();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule